// File: doc/BRIEF.md
# Coprocessor Two-Word Load/Store Sequencer

This block sits between a 32-bit host data bus and a coprocessor register file that holds sixteen 64-bit registers. It serves coprocessor load and store instructions. A load instruction writes words from the bus into a register. A store instruction drives words from a register onto the read-data output. A long access moves a full 64-bit register in two bus beats. A short access moves one 32-bit word.

For a long access, the big-endian configuration input decides which half of the register goes with the first beat. For a short access, a mode input picks the transfer type. A floating-point word lives in the upper half of the register. An integer word lives in the lower half, and an integer load also sign-extends into the upper half.

The host presents one beat per cycle. On each beat it supplies the instruction word, a flag that says whether the beat carries data, and a direction input. For each data beat the block answers "increment" (another beat follows) or "done". A non-data beat restarts the sequence. Address generation belongs to the host.

Top module: `cx_ldst_seq`

## Requirements
- R1: After reset every register of the file reads as zero, and the beat sequence starts at its first beat.
- R2: The access length and the register come from the instruction word. Bit 22 set selects a long (two-word) access and clear selects a short (one-word) access. Bits 15:12 select the register. Every short data beat answers done (`resp_inc_o` = 0).
- R3: For a long access, the first data beat answers increment (`resp_inc_o` = 1) and the second data beat answers done. Cycles with `beat_valid_i` = 0 between the two beats do not advance the sequence.
- R4: For a long access with `big_endian_i` = 1, the first beat uses bits 63:32 of the register and the second beat uses bits 31:0. With `big_endian_i` = 0 the order is reversed. This holds for both loads and stores.
- R5: A beat with `beat_is_data_i` = 0 answers done, changes no register, and returns the sequence to its first beat.
- R6: A short load with `int_mode_i` = 0 (float type) writes bits 63:32 and leaves bits 31:0 unchanged.
- R7: A short load with `int_mode_i` = 1 (integer type) writes bits 31:0 and fills bits 63:32 with copies of bit 31 of the written word.
- R8: A short store returns bits 63:32 when `int_mode_i` = 0 and bits 31:0 when `int_mode_i` = 1.
- R9: When no beat is presented, `resp_inc_o` is 0. Whenever the cycle is not a store data beat, `rdata_o` is 0.
- R10: Store beats never modify the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| beat_valid_i | input | 1 | A bus beat is presented this cycle |
| beat_is_data_i | input | 1 | 1 for a data beat, 0 for a non-data beat |
| is_load_i | input | 1 | 1 for a load (bus to register), 0 for a store |
| int_mode_i | input | 1 | 1 for integer-type transfers, 0 for float-type transfers |
| big_endian_i | input | 1 | Word order of a long access |
| instr_i | input | 32 | Instruction word (bit 22 sets length, bits 15:12 select the register) |
| wdata_i | input | 32 | Word to load into the register file |
| rdata_o | output | 32 | Word read out by a store beat, 0 otherwise |
| resp_inc_o | output | 1 | 1 = increment (more beats follow), 0 = done |

## Verification
The bench builds the block with its default parameters: sixteen registers and 32-bit words. Random register indices therefore reach every entry, and random data puts the word sign bit at bit 31, which exercises sign extension in both directions. Long accesses are mixed with idle cycles and non-data beats in between, and both word orders are used. This makes partial long loads and restarted sequences common. Every register written by a load is read back later through store beats and compared against a bench model.

// File: rtl/cx_ldst_pkg.sv
package cx_ldst_pkg;
    // Instruction field positions decoded by this block
    localparam int LONG_BIT = 22;
    localparam int IDX_LSB  = 12;

    // Sequencer state: has the first beat of a long access been taken?
    typedef struct packed {
        logic second;
    } seq_st_t;
endpackage

// File: rtl/cx_ldst_ctrl.sv
module cx_ldst_ctrl
    import cx_ldst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_valid,
    input  logic beat_is_data,
    input  logic long_acc,
    input  logic big_endian,
    input  logic int_mode,
    output logic resp_inc,
    output logic sel_hi
);
    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (beat_valid) begin
            if (!beat_is_data) begin
                st_d.second = 1'b0;
            end else if (long_acc) begin
                st_d.second = ~st_q.second;
            end else begin
                st_d.second = 1'b0;
            end
        end
        resp_inc = beat_valid & beat_is_data & long_acc & ~st_q.second;
        if (long_acc) begin
            sel_hi = st_q.second ? ~big_endian : big_endian;
        end else begin
            sel_hi = ~int_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cx_ldst_rf.sv
module cx_ldst_rf #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG),
    localparam int RW  = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] idx,
    input  logic          wr_hi_en,
    input  logic          wr_lo_en,
    input  logic [DW-1:0] wr_hi_data,
    input  logic [DW-1:0] wr_lo_data,
    output logic [RW-1:0] rd_word
);
    logic [RW-1:0] bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic [RW-1:0] ent_d, ent_q;
        logic          hit;

        always_comb begin
            hit   = (idx == AW'(g));
            ent_d = ent_q;
            if (hit && wr_hi_en) ent_d[RW-1:DW] = wr_hi_data;
            if (hit && wr_lo_en) ent_d[DW-1:0]  = wr_lo_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign bank[g] = ent_q;
    end

    assign rd_word = bank[idx];
endmodule

// File: rtl/cx_ldst_seq.sv
module cx_ldst_seq
    import cx_ldst_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int IW   = 32,
    localparam int AW  = $clog2(NREG),
    localparam int RW  = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_valid_i,
    input  logic          beat_is_data_i,
    input  logic          is_load_i,
    input  logic          int_mode_i,
    input  logic          big_endian_i,
    input  logic [IW-1:0] instr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          resp_inc_o
);
    logic          long_acc;
    logic [AW-1:0] reg_idx;
    logic          sel_hi;
    logic          data_beat;
    logic          load_beat;
    logic          wr_hi_en, wr_lo_en;
    logic [DW-1:0] wr_hi_data;
    logic [RW-1:0] rd_word;

    assign long_acc = instr_i[LONG_BIT];
    assign reg_idx  = instr_i[IDX_LSB +: AW];

    cx_ldst_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_valid   (beat_valid_i),
        .beat_is_data (beat_is_data_i),
        .long_acc     (long_acc),
        .big_endian   (big_endian_i),
        .int_mode     (int_mode_i),
        .resp_inc     (resp_inc_o),
        .sel_hi       (sel_hi)
    );

    always_comb begin
        data_beat  = beat_valid_i & beat_is_data_i;
        load_beat  = data_beat & is_load_i;
        // A short integer load also fills the upper half with the sign
        wr_hi_en   = load_beat & (sel_hi | (~long_acc & int_mode_i));
        wr_lo_en   = load_beat & ~sel_hi;
        wr_hi_data = sel_hi ? wdata_i : {DW{wdata_i[DW-1]}};
        if (data_beat && !is_load_i) begin
            rdata_o = sel_hi ? rd_word[RW-1:DW] : rd_word[DW-1:0];
        end else begin
            rdata_o = '0;
        end
    end

    cx_ldst_rf #(.NREG(NREG), .DW(DW)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (reg_idx),
        .wr_hi_en   (wr_hi_en),
        .wr_lo_en   (wr_lo_en),
        .wr_hi_data (wr_hi_data),
        .wr_lo_data (wdata_i),
        .rd_word    (rd_word)
    );
endmodule

// File: rtl/cx_ldst_seq_chk.sv
module cx_ldst_seq_chk #(
    parameter int DW = 32,
    parameter int IW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          beat_valid_i,
    input logic          beat_is_data_i,
    input logic          is_load_i,
    input logic [IW-1:0] instr_i,
    input logic [DW-1:0] rdata_o,
    input logic          resp_inc_o
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R9: no beat, no increment
    a_r9_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid_i |-> !resp_inc_o);

    // R9: read data is quiet outside store data beats
    a_r9_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_valid_i && beat_is_data_i && !is_load_i) |-> (rdata_o == '0));

    // R2: short data beats finish at once
    a_r2_short_done: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_i && beat_is_data_i && !instr_i[22]) |-> !resp_inc_o);

    // R5: non-data beat answers done
    a_r5_nondata_done: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_i && !beat_is_data_i) |-> !resp_inc_o);

    // R5: after a non-data beat the next long data beat is a first beat
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(beat_valid_i && !beat_is_data_i)
         && beat_valid_i && beat_is_data_i && instr_i[22]) |-> resp_inc_o);

    // R3: an increment beat followed directly by a long data beat ends it
    a_r3_second_done: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(resp_inc_o)
         && beat_valid_i && beat_is_data_i && instr_i[22]) |-> !resp_inc_o);
endmodule

bind cx_ldst_seq cx_ldst_seq_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .beat_valid_i   (beat_valid_i),
    .beat_is_data_i (beat_is_data_i),
    .is_load_i      (is_load_i),
    .instr_i        (instr_i),
    .rdata_o        (rdata_o),
    .resp_inc_o     (resp_inc_o)
);

// File: tb/cx_ldst_seq_test.sv
module cx_ldst_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_valid_i = 1'b0;
    logic        beat_is_data_i = 1'b0;
    logic        is_load_i = 1'b0;
    logic        int_mode_i = 1'b0;
    logic        big_endian_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        resp_inc_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [63:0] mdl [16];
    bit          mcnt;

    always #5 clk = ~clk;

    cx_ldst_seq uut (
        .clk(clk), .rst_n(rst_n), .beat_valid_i(beat_valid_i),
        .beat_is_data_i(beat_is_data_i), .is_load_i(is_load_i),
        .int_mode_i(int_mode_i), .big_endian_i(big_endian_i),
        .instr_i(instr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .resp_inc_o(resp_inc_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit pick_hi(bit cnt, bit lng, bit be, bit im);
        return lng ? (cnt ? !be : be) : !im;
    endfunction

    // One beat: drive, settle, compare, then advance the model
    task automatic beat(input bit v, input bit d, input bit ld, input bit im,
                        input bit be, input int idx, input bit lng,
                        input logic [31:0] wd, input string tag);
        logic [31:0] ins;
        bit          hi, exp_inc;
        logic [31:0] exp_rd;
        string       t_resp, t_rd;
        @(negedge clk);
        ins = $urandom();
        ins[22] = lng;
        ins[15:12] = idx[3:0];
        beat_valid_i = v; beat_is_data_i = d; is_load_i = ld;
        int_mode_i = im; big_endian_i = be; instr_i = ins; wdata_i = wd;
        #1;
        hi      = pick_hi(mcnt, lng, be, im);
        exp_inc = v && d && lng && !mcnt;
        exp_rd  = (v && d && !ld) ? (hi ? mdl[idx][63:32] : mdl[idx][31:0]) : 32'h0;
        t_resp = tag != "" ? tag : (!v ? "R9" : (!d ? "R5" : (lng ? "R3" : "R2")));
        t_rd   = tag != "" ? tag : ((!v || !d || ld) ? "R9" : (lng ? "R4" : "R8"));
        check(resp_inc_o == exp_inc, t_resp, 32'(resp_inc_o), 32'(exp_inc));
        check(rdata_o == exp_rd, t_rd, rdata_o, exp_rd);
        if (v) begin
            if (d && ld) begin
                if (lng) begin
                    if (hi) mdl[idx][63:32] = wd; else mdl[idx][31:0] = wd;
                end else if (im) begin
                    mdl[idx] = {{32{wd[31]}}, wd};
                end else begin
                    mdl[idx][63:32] = wd;
                end
            end
            mcnt = (d && lng) ? !mcnt : 1'b0;
        end
    endtask

    task automatic idle();
        beat(0, 0, 0, 0, 0, 0, 0, 32'h0, "");
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        mcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero, both halves
        for (int r = 0; r < 16; r++) begin
            beat(1, 1, 0, 1, 0, r, 0, 32'h0, "R1");
            beat(1, 1, 0, 0, 0, r, 0, 32'h0, "R1");
        end
        // R1: first long beat after reset increments
        beat(1, 1, 0, 0, 1, 2, 1, 32'h0, "R1");
        beat(1, 1, 0, 0, 1, 2, 1, 32'h0, "R3");

        // R4: big-endian long load, then little-endian long store
        beat(1, 1, 1, 0, 1, 5, 1, 32'h1111_1111, "R4");
        idle();
        beat(1, 1, 1, 0, 1, 5, 1, 32'h2222_2222, "R4");
        beat(1, 1, 0, 0, 0, 5, 1, 32'h0, "R4");
        beat(1, 1, 0, 0, 0, 5, 1, 32'h0, "R4");
        beat(1, 1, 0, 0, 0, 5, 0, 32'h0, "R8");

        // R7: negative short integer load, read back as a long
        beat(1, 1, 1, 1, 0, 7, 0, 32'h8000_0005, "R7");
        beat(1, 1, 0, 0, 0, 7, 1, 32'h0, "R7");
        beat(1, 1, 0, 0, 0, 7, 1, 32'h0, "R7");

        // R6: float short load keeps the lower half
        beat(1, 1, 1, 0, 0, 9, 1, 32'hAAAA_0001, "R6");
        beat(1, 1, 1, 0, 0, 9, 1, 32'hBBBB_0002, "R6");
        beat(1, 1, 1, 0, 0, 9, 0, 32'hCCCC_0003, "R6");
        beat(1, 1, 0, 1, 0, 9, 0, 32'h0, "R6");
        beat(1, 1, 0, 0, 0, 9, 0, 32'h0, "R6");

        // R5: non-data beat aborts a long access
        beat(1, 1, 1, 0, 1, 3, 1, 32'h3333_3333, "R5");
        beat(1, 0, 1, 0, 1, 3, 1, 32'hDEAD_BEEF, "R5");
        beat(1, 1, 0, 0, 1, 3, 1, 32'h0, "R5");
        beat(1, 1, 0, 0, 1, 3, 1, 32'h0, "R5");

        // R10: two identical stores return the same words
        beat(1, 1, 0, 0, 1, 5, 1, 32'h0, "R10");
        beat(1, 1, 0, 0, 1, 5, 1, 32'h0, "R10");
        beat(1, 1, 0, 0, 1, 5, 1, 32'h0, "R10");
        beat(1, 1, 0, 0, 1, 5, 1, 32'h0, "R10");

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            int  k, r;
            bit  ld, im, be;
            k  = $urandom_range(0, 19);
            r  = $urandom_range(0, 15);
            ld = $urandom_range(0, 1) != 0;
            im = $urandom_range(0, 1) != 0;
            be = $urandom_range(0, 1) != 0;
            if (k < 2) begin
                idle();
            end else if (k < 4) begin
                beat(1, 0, ld, im, be, r, $urandom_range(0, 1) != 0, $urandom(), "");
            end else if (k < 11) begin
                beat(1, 1, ld, im, be, r, 0, $urandom(), "");
            end else begin
                beat(1, 1, ld, im, be, r, 1, $urandom(), "");
                if ($urandom_range(0, 5) == 0) idle();
                if ($urandom_range(0, 7) == 0)
                    beat(1, 0, ld, im, be, r, 1, $urandom(), "");
                beat(1, 1, ld, im, be, r, 1, $urandom(), "");
            end
        end

        // R10: sweep back every register after random traffic
        for (int r = 0; r < 16; r++) begin
            beat(1, 0, 0, 0, 0, r, 0, 32'h0, "R5");
            beat(1, 1, 0, 0, 1, r, 1, 32'h0, "R10");
            beat(1, 1, 0, 0, 1, r, 1, 32'h0, "R10");
        end
        idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule